// File: doc/BRIEF.md
# Address-Filtering HDLC Channel Receiver

This block receives one serial bearer channel, one bit per strobe, and turns it into byte writes for a receive FIFO. In framed mode it looks for flag octets (0x7E) to find frame boundaries. It removes the zeros that the sender inserted after runs of ones, checks the frame check sequence, and compares the first octet of each frame with a programmed station address. Only frames addressed to this station, or to the broadcast address, reach the FIFO. For each such frame the block gives an end-of-frame pulse with a good/bad verdict. A run of seven ones aborts the frame that is in progress.

In extended transparent mode the block applies no framing. Every received bit is packed into bytes, least significant bit first, and each byte is written as it completes. An enable input puts the channel to sleep: while it is low, strobes are ignored and all receive state is held cleared. This matches a channel whose bit clock is stopped to save power.

Top module: `hdlc_addr_filter_rx`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `rx_active` at 0, `fifo_we`, `frame_done`, `frame_good` and `frame_abort` are 0. Strobes that arrive while `rx_active` is 0 are ignored. A frame that deactivation cuts off never produces a write or an end-of-frame pulse.
- R2: In framed mode (`xt_mode`=0) the flag octet 0x7E opens and closes frames. Bits received before the first flag, and idle ones between frames, produce no output.
- R3: Inside a frame, a 0 that follows five consecutive data 1s is discarded. The remaining bits form bytes, first received bit in bit 0.
- R4: The first byte of a frame is the address. A frame whose address is neither `own_addr` nor 0xFF produces no write and no end-of-frame pulse.
- R5: For an accepted frame, every byte except the last two is written in order. `frame_done` pulses for one cycle, in the cycle after the strobe that delivered the last bit of the closing flag.
- R6: `frame_good` is 1 only together with `frame_done`. It is 1 when three conditions all hold: the frame holds at least 4 whole bytes; no bits are left over beyond a whole byte; and CRC-16-CCITT over all bytes, including the two check bytes, leaves the residue 0xF0B8. The CRC uses the reflected polynomial 0x8408, is preset to 0xFFFF and is fed least significant bit first. The sender transmits the inverted CRC, low byte first.
- R7: The receiver detects seven consecutive raw 1s as an abort. If any frame bit has passed the flag detector since the last flag, `frame_abort` pulses for one cycle, in the cycle after the seventh 1. In either case no `frame_done` follows, and the receiver waits for a new flag.
- R8: In extended transparent mode (`xt_mode`=1) every strobed bit is packed LSB first. A byte is written in the cycle after every eighth strobe counted from activation. Flags, runs of ones and stuffing have no effect, and `frame_done` and `frame_abort` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_active | input | 1 | Receiver enable; 0 stops and clears reception |
| xt_mode | input | 1 | 0 framed mode, 1 extended transparent mode; change only while `rx_active` is 0 |
| own_addr | input | 8 | Station address matched against the first frame byte |
| bit_en | input | 1 | One-cycle strobe qualifying `bit_in` |
| bit_in | input | 1 | Serial receive data |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | 8 | Byte to write |
| frame_done | output | 1 | End of an accepted frame |
| frame_good | output | 1 | Verdict qualified by `frame_done` |
| frame_abort | output | 1 | Frame ended by an abort run |

## Verification
All results are registered one stage after the strobe that causes them. An end-of-frame pulse is due in the cycle after the last bit of the closing flag. An abort pulse is due in the cycle after the seventh 1. A transparent-mode write is due in the cycle after each eighth strobe. In framed mode a frame byte reaches the FIFO only once the next two bytes have arrived. The bench counts the strobes the design has sampled and stamps each observed pulse with that count, sampling on the falling edge. It then compares each stamp with the strobe index it recorded while serialising the closing flag, the seventh abort 1 or the eighth transparent bit. In framed mode the order and content of the written bytes are checked, not their cycle, because the byte delay depends on stuffing.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [15:0] CRC_PRESET    = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE   = 16'hF0B8;
  localparam logic [7:0]  FLAG_OCTET    = 8'h7E;
  localparam logic [7:0]  BCAST_ADDR    = 8'hFF;

  // One serial step of the reflected CRC-16-CCITT.
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY_REFL : 16'h0000);
  endfunction

  // Address acceptance: own station or broadcast.
  function automatic logic addr_accept(input logic [7:0] a, input logic [7:0] own);
    return (a == own) || (a == BCAST_ADDR);
  endfunction
endpackage

// File: rtl/hdlc_rx_window.sv
// Raw-bit window: finds flags and abort runs, and passes frame bits on with an
// eight-bit delay so that flag bits never reach the byte side.
module hdlc_rx_window #(
  parameter int WIN       = 8,
  parameter int ABORT_RUN = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stb,
  input  logic din,
  output logic ev_bit_vld,
  output logic ev_bit,
  output logic ev_flag,
  output logic ev_abort
);
  import hdlc_rx_pkg::*;
  localparam int VC_W  = $clog2(WIN + 1);
  localparam int RUN_W = $clog2(ABORT_RUN + 1);
  localparam logic [VC_W-1:0]  VC_FULL  = VC_W'(WIN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(ABORT_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(ABORT_RUN);

  logic [WIN-1:0]   win_q;
  logic [WIN-1:0]   win_n;
  logic [VC_W-1:0]  vcnt_q;
  logic [RUN_W-1:0] run_q;
  logic             open_q;

  always_comb begin
    win_n      = {win_q[WIN-2:0], din};
    ev_flag    = stb && (win_n == FLAG_OCTET);
    ev_abort   = stb && open_q && din && (run_q == RUN_LAST);
    ev_bit_vld = stb && open_q && (vcnt_q == VC_FULL);
    ev_bit     = win_q[WIN-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      win_q  <= '0;
      vcnt_q <= '0;
      run_q  <= '0;
      open_q <= 1'b0;
    end else if (stb) begin
      win_q <= win_n;
      if (!din)                 run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      if (ev_flag) begin
        vcnt_q <= '0;
        open_q <= 1'b1;
      end else if (ev_abort) begin
        vcnt_q <= '0;
        open_q <= 1'b0;
      end else if (vcnt_q != VC_FULL) begin
        vcnt_q <= vcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_framer.sv
// Byte side of framed mode: destuffing, byte assembly, CRC, address filter and
// a pipeline that holds back the check bytes.
module hdlc_rx_framer #(
  parameter int STUFF_RUN = 5,
  parameter int MIN_BYTES = 4,
  parameter int FCS_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       bit_vld,
  input  logic       bit_val,
  input  logic       flag,
  input  logic       abort,
  input  logic [7:0] own_addr,
  output logic       we,
  output logic [7:0] wdata,
  output logic       done,
  output logic       good,
  output logic       abrt
);
  import hdlc_rx_pkg::*;
  localparam int ONES_W = $clog2(STUFF_RUN + 2);
  localparam int NB_W   = $clog2(MIN_BYTES + 1);
  localparam int PC_W   = $clog2(FCS_BYTES + 1);
  localparam logic [ONES_W-1:0] ONES_STUFF = ONES_W'(STUFF_RUN);
  localparam logic [NB_W-1:0]   NB_MIN     = NB_W'(MIN_BYTES);
  localparam logic [PC_W-1:0]   PC_FULL    = PC_W'(FCS_BYTES);

  logic [ONES_W-1:0] ones_q, ones_n;
  logic [7:0]        sr_q, sr_n;
  logic [2:0]        bcnt_q, bcnt_n;
  logic [NB_W-1:0]   nb_q, nb_n;
  logic [PC_W-1:0]   pc_q, pc_n;
  logic [15:0]       crc_q, crc_n;
  logic              addr_q, addr_n;
  logic              started_q, started_n;
  logic [7:0]        pend_q [FCS_BYTES];
  logic [7:0]        pend_n [FCS_BYTES];
  logic              byte_done, push_we, stuffed;
  logic [7:0]        push_data;

  always_comb begin
    ones_n = ones_q;  sr_n = sr_q;  bcnt_n = bcnt_q;  nb_n = nb_q;
    pc_n = pc_q;  crc_n = crc_q;  addr_n = addr_q;  started_n = started_q;
    pend_n = pend_q;
    byte_done = 1'b0;  push_we = 1'b0;  push_data = pend_q[FCS_BYTES-1];
    stuffed = bit_vld && !bit_val && (ones_q == ONES_STUFF);
    if (bit_vld) begin
      started_n = 1'b1;
      if (stuffed) begin
        ones_n = '0;
      end else begin
        if (!bit_val)               ones_n = '0;
        else if (ones_q != ONES_STUFF) ones_n = ones_q + 1'b1;
        crc_n     = crc_step(crc_q, bit_val);
        sr_n      = {bit_val, sr_q[7:1]};
        bcnt_n    = bcnt_q + 1'b1;
        byte_done = (bcnt_q == 3'd7);
      end
    end
    if (byte_done) begin
      if (nb_q == '0) addr_n = addr_accept(sr_n, own_addr);
      if (nb_q != NB_MIN) nb_n = nb_q + 1'b1;
      if (pc_q == PC_FULL) push_we = addr_q;
      else                 pc_n = pc_q + 1'b1;
      for (int i = FCS_BYTES - 1; i > 0; i--) pend_n[i] = pend_q[i-1];
      pend_n[0] = sr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      we <= 1'b0;  wdata <= '0;  done <= 1'b0;  good <= 1'b0;  abrt <= 1'b0;
      ones_q <= '0;  sr_q <= '0;  bcnt_q <= '0;  nb_q <= '0;  pc_q <= '0;
      crc_q <= CRC_PRESET;  addr_q <= 1'b0;  started_q <= 1'b0;
      for (int i = 0; i < FCS_BYTES; i++) pend_q[i] <= '0;
    end else begin
      we    <= push_we;
      wdata <= push_data;
      done  <= 1'b0;
      good  <= 1'b0;
      abrt  <= 1'b0;
      if (flag || abort) begin
        if (flag) begin
          done <= started_n && addr_n && (nb_n != '0);
          good <= started_n && addr_n && (nb_n == NB_MIN) && (bcnt_n == 3'd0)
                  && (crc_n == CRC_RESIDUE);
        end else begin
          abrt <= started_n;
        end
        ones_q <= '0;  sr_q <= '0;  bcnt_q <= '0;  nb_q <= '0;  pc_q <= '0;
        crc_q <= CRC_PRESET;  addr_q <= 1'b0;  started_q <= 1'b0;
      end else begin
        ones_q <= ones_n;  sr_q <= sr_n;  bcnt_q <= bcnt_n;  nb_q <= nb_n;
        pc_q <= pc_n;  crc_q <= crc_n;  addr_q <= addr_n;  started_q <= started_n;
        pend_q <= pend_n;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_xt_packer.sv
// Extended transparent mode: packs every strobed bit, LSB first.
module hdlc_rx_xt_packer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stb,
  input  logic              din,
  output logic              we,
  output logic [BYTE_W-1:0] wdata
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sr_q, sr_n;

  assign sr_n = {din, sr_q[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;  sr_q <= '0;  we <= 1'b0;  wdata <= '0;
    end else begin
      we <= 1'b0;
      if (stb) begin
        sr_q  <= sr_n;
        cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) begin
          we    <= 1'b1;
          wdata <= sr_n;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_addr_filter_rx.sv
module hdlc_addr_filter_rx #(
  parameter int STUFF_RUN = 5,
  parameter int ABORT_RUN = 7,
  parameter int MIN_BYTES = 4,
  parameter int FCS_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_active,
  input  logic       xt_mode,
  input  logic [7:0] own_addr,
  input  logic       bit_en,
  input  logic       bit_in,
  output logic       fifo_we,
  output logic [7:0] fifo_wdata,
  output logic       frame_done,
  output logic       frame_good,
  output logic       frame_abort
);
  logic clr, fr_stb, xt_stb;
  logic w_bit_vld, w_bit, w_flag, w_abort;
  logic fr_we, xt_we;
  logic [7:0] fr_wdata, xt_wdata;

  assign clr    = !rx_active;
  assign fr_stb = bit_en && rx_active && !xt_mode;
  assign xt_stb = bit_en && rx_active && xt_mode;

  hdlc_rx_window #(.WIN(8), .ABORT_RUN(ABORT_RUN)) u_window (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stb(fr_stb), .din(bit_in),
    .ev_bit_vld(w_bit_vld), .ev_bit(w_bit), .ev_flag(w_flag), .ev_abort(w_abort)
  );

  hdlc_rx_framer #(.STUFF_RUN(STUFF_RUN), .MIN_BYTES(MIN_BYTES), .FCS_BYTES(FCS_BYTES)) u_framer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(w_bit_vld), .bit_val(w_bit),
    .flag(w_flag), .abort(w_abort), .own_addr(own_addr),
    .we(fr_we), .wdata(fr_wdata), .done(frame_done), .good(frame_good), .abrt(frame_abort)
  );

  hdlc_rx_xt_packer #(.BYTE_W(8)) u_xt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stb(xt_stb), .din(bit_in),
    .we(xt_we), .wdata(xt_wdata)
  );

  assign fifo_we    = fr_we | xt_we;
  assign fifo_wdata = xt_we ? xt_wdata : fr_wdata;
endmodule

// File: rtl/hdlc_addr_filter_rx_chk.sv
module hdlc_addr_filter_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_active,
  input logic xt_mode,
  input logic bit_en,
  input logic fifo_we,
  input logic frame_done,
  input logic frame_good,
  input logic frame_abort,
  input logic w_flag,
  input logic w_abort
);
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |=> !(fifo_we || frame_done || frame_abort || frame_good)); // R1
  AST_FLAG_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_flag && w_abort)); // R2
  AST_WE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> $past(bit_en && rx_active)); // R5
  AST_DONE_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(w_flag)); // R5
  AST_GOOD_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_good |-> frame_done); // R6
  AST_ABORT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> ($past(w_abort) && !frame_done)); // R7
  AST_XT_NO_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    (xt_mode && $past(xt_mode)) |-> !(frame_done || frame_abort)); // R8
endmodule

bind hdlc_addr_filter_rx hdlc_addr_filter_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .xt_mode(xt_mode), .bit_en(bit_en),
  .fifo_we(fifo_we), .frame_done(frame_done), .frame_good(frame_good),
  .frame_abort(frame_abort), .w_flag(w_flag), .w_abort(w_abort)
);

// File: tb/hdlc_addr_filter_rx_bench.sv
module hdlc_addr_filter_rx_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, rx_active = 1'b0, xt_mode = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
  logic [7:0] own_addr = 8'h5A;
  logic fifo_we, frame_done, frame_good, frame_abort;
  logic [7:0] fifo_wdata;

  hdlc_addr_filter_rx u_hdlc_addr_filter_rx (
    .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .xt_mode(xt_mode), .own_addr(own_addr),
    .bit_en(bit_en), .bit_in(bit_in), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
    .frame_done(frame_done), .frame_good(frame_good), .frame_abort(frame_abort)
  );

  int errors = 0, checks = 0, edge_cnt = 0, run1 = 0;
  int exp_d_stamp = -1, exp_a_stamp = -1;
  bit exp_d_good = 1'b0, ignore_w = 1'b0;
  byte unsigned exp_w[$], act_w[$];
  int act_w_stamp[$], act_d_stamp[$], act_a_stamp[$];
  bit act_d_good[$];

  always @(posedge clk) if (bit_en && rx_active) edge_cnt++;

  always @(negedge clk) if (rst_n) begin
    if (fifo_we) begin act_w.push_back(fifo_wdata); act_w_stamp.push_back(edge_cnt); end
    if (frame_done) begin act_d_stamp.push_back(edge_cnt); act_d_good.push_back(frame_good); end
    if (frame_abort) act_a_stamp.push_back(edge_cnt);
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Byte-wise reflected CRC, preset all ones.
  function automatic logic [15:0] crc_ref(input byte unsigned q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[k]) begin
      c ^= {8'h00, q[k]};
      for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  function automatic bit addr_ref(input byte unsigned a);
    return (a == own_addr) || (a == 8'hFF);
  endfunction

  task automatic send_raw(input bit b);
    repeat ($urandom_range(0, 2)) @(posedge clk);
    @(posedge clk) #1;
    bit_en = 1'b1; bit_in = b;
    @(posedge clk) #1;
    bit_en = 1'b0;
  endtask

  task automatic send_stuffed(input bit b);
    send_raw(b);
    if (b) begin
      run1++;
      if (run1 == 5) begin send_raw(1'b0); run1 = 0; end
    end else run1 = 0;
  endtask

  task automatic send_flag();
    send_raw(1'b0);
    repeat (6) send_raw(1'b1);
    send_raw(1'b0);
    run1 = 0;
  endtask

  task automatic send_frame(input byte unsigned q[$], input bit add_fcs, input bit corrupt,
                            input int extra, input bit expect_on);
    byte unsigned all[$];
    logic [15:0] c;
    all = q;
    if (add_fcs) begin
      c = ~crc_ref(q);
      if (corrupt) c ^= 16'h0010;
      all.push_back(c[7:0]);
      all.push_back(c[15:8]);
    end
    repeat (9) send_raw(1'b1);
    send_flag();
    foreach (all[k]) for (int i = 0; i < 8; i++) send_stuffed(all[k][i]);
    for (int i = 0; i < extra; i++) send_stuffed(i[0]);
    send_flag();
    if (expect_on && all.size() > 0 && addr_ref(all[0])) begin
      for (int k = 0; k < int'(all.size()) - 2; k++) exp_w.push_back(all[k]);
      exp_d_stamp = edge_cnt;
      exp_d_good  = add_fcs && !corrupt && all.size() >= 4 && extra == 0;
    end else exp_d_stamp = -1;
  endtask

  task automatic compare(input string req);
    repeat (3) @(negedge clk);
    if (!ignore_w) begin
      check(act_w.size() == exp_w.size(), req, "write count", act_w.size(), exp_w.size());
      for (int k = 0; k < act_w.size() && k < exp_w.size(); k++)
        check(act_w[k] == exp_w[k], req, $sformatf("byte %0d", k), act_w[k], exp_w[k]);
    end
    if (exp_d_stamp < 0) check(act_d_stamp.size() == 0, req, "end-of-frame count", act_d_stamp.size(), 0);
    else begin
      check(act_d_stamp.size() == 1, req, "end-of-frame count", act_d_stamp.size(), 1);
      if (act_d_stamp.size() == 1) begin
        check(act_d_stamp[0] == exp_d_stamp, req, "end-of-frame strobe", act_d_stamp[0], exp_d_stamp);
        check(act_d_good[0] == exp_d_good, req, "good verdict", act_d_good[0], exp_d_good);
      end
    end
    if (exp_a_stamp < 0) check(act_a_stamp.size() == 0, req, "abort count", act_a_stamp.size(), 0);
    else begin
      check(act_a_stamp.size() == 1, req, "abort count", act_a_stamp.size(), 1);
      if (act_a_stamp.size() == 1)
        check(act_a_stamp[0] == exp_a_stamp, req, "abort strobe", act_a_stamp[0], exp_a_stamp);
    end
    exp_w.delete(); act_w.delete(); act_w_stamp.delete(); act_d_stamp.delete();
    act_d_good.delete(); act_a_stamp.delete();
    exp_d_stamp = -1; exp_a_stamp = -1; ignore_w = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    byte unsigned q[$];
    byte unsigned xb[$];
    int base;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!fifo_we && !frame_done && !frame_good && !frame_abort, "R1", "outputs after reset",
          {fifo_we, frame_done, frame_good, frame_abort}, 0);
    rx_active = 1'b1;

    // R2 R5 R6: plain good frame to own address
    q = '{8'h5A, 8'h03, 8'h11, 8'h22};
    send_frame(q, 1, 0, 0, 1); compare("R5");
    // R4: broadcast accepted, foreign address dropped
    q = '{8'hFF, 8'h13, 8'hC4};
    send_frame(q, 1, 0, 0, 1); compare("R4");
    q = '{8'h5B, 8'h03, 8'h99, 8'h42};
    send_frame(q, 1, 0, 0, 1); compare("R4");
    // R3: payload full of ones and flag-like octets
    q = '{8'h5A, 8'hFF, 8'h7E, 8'hFF, 8'hFF, 8'hF8};
    send_frame(q, 1, 0, 0, 1); compare("R3");
    // R6: corrupted check, short frames, leftover bits
    q = '{8'h5A, 8'h03, 8'h55};
    send_frame(q, 1, 1, 0, 1); compare("R6");
    q = '{8'h5A, 8'h03};
    send_frame(q, 0, 0, 0, 1); compare("R6");
    q = '{8'h5A};
    send_frame(q, 1, 0, 0, 1); compare("R6");
    q = '{8'h5A, 8'h03, 8'h21};
    send_frame(q, 1, 0, 3, 1); compare("R6");

    // R7: abort run inside a frame, then recovery
    repeat (9) send_raw(1'b1);
    send_flag();
    q = '{8'h5A, 8'h03, 8'h11};
    foreach (q[k]) for (int i = 0; i < 8; i++) send_stuffed(q[k][i]);
    send_raw(1'b0);
    repeat (7) send_raw(1'b1);
    exp_a_stamp = edge_cnt;
    repeat (4) send_raw(1'b1);
    ignore_w = 1'b1;
    compare("R7");
    q = '{8'h5A, 8'h01, 8'hA5};
    send_frame(q, 1, 0, 0, 1); compare("R7");

    // R1: strobes ignored while inactive, cut-off frame discarded
    rx_active = 1'b0;
    q = '{8'h5A, 8'h03, 8'h77};
    send_frame(q, 1, 0, 0, 0); compare("R1");
    rx_active = 1'b1;
    send_flag();
    for (int i = 0; i < 12; i++) send_stuffed(i[1]);
    rx_active = 1'b0;
    repeat (3) @(posedge clk);
    rx_active = 1'b1;
    q = '{8'h5A, 8'h0F, 8'h3C};
    send_frame(q, 1, 0, 0, 1); compare("R1");

    // Random frames mixing addresses, lengths and corruption
    for (int n = 0; n < 10; n++) begin
      int sel;
      q.delete();
      sel = $urandom_range(0, 2);
      q.push_back(sel == 0 ? own_addr : (sel == 1 ? 8'hFF : 8'h33));
      repeat ($urandom_range(1, 5)) q.push_back(8'($urandom));
      send_frame(q, 1, ($urandom_range(0, 3) == 0), 0, 1);
      compare("R5");
    end

    // R8: extended transparent mode
    rx_active = 1'b0;
    repeat (2) @(posedge clk);
    xt_mode = 1'b1;
    @(posedge clk) #1 rx_active = 1'b1;
    base = edge_cnt;
    xb = '{8'h7E, 8'hFF, 8'hFF, 8'($urandom), 8'h00, 8'($urandom)};
    foreach (xb[k]) for (int i = 0; i < 8; i++) send_raw(xb[k][i]);
    repeat (3) @(negedge clk);
    check(act_w.size() == xb.size(), "R8", "transparent write count", act_w.size(), xb.size());
    for (int k = 0; k < act_w.size() && k < xb.size(); k++) begin
      check(act_w[k] == xb[k], "R8", $sformatf("transparent byte %0d", k), act_w[k], xb[k]);
      check(act_w_stamp[k] == base + 8 * (k + 1), "R8", $sformatf("transparent strobe %0d", k),
            act_w_stamp[k], base + 8 * (k + 1));
    end
    ignore_w = 1'b1;
    compare("R8");
    rx_active = 1'b0;
    repeat (2) @(posedge clk);
    xt_mode = 1'b0;
    @(posedge clk) #1 rx_active = 1'b1;
    q = '{8'h5A, 8'h03, 8'hEE};
    send_frame(q, 1, 0, 0, 1); compare("R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule